// File: doc/BRIEF.md
# Oldest-First Out-of-Order Issue Queue

This block holds renamed instructions between dispatch and execution. Each entry carries two physical source tags with ready flags, a destination tag, a sequence number and an opaque payload. Each cycle, destination tags broadcast by finishing operations mark matching waiting sources as ready. Entries whose sources are both ready are then candidates for issue.

The queue is always kept packed, with the oldest entry in slot 0. The position of an entry is therefore its age. Each cycle the selector takes the first ready entries in position order, up to the issue width. It presents them on the issue ports with the oldest in slot 0, and drops them from the queue at the clock edge that closes the cycle. Survivors slide toward the head and newly accepted instructions are appended behind them. A flush input removes every entry younger than a given sequence number within one cycle. The default parameters suit a twenty-entry, four-wide integer queue. A fifteen-entry, two-wide floating-point queue is the same module with other parameter values.

Top module: `iq_top`

## Requirements
- R1: While `rst` is high and after it falls, the queue is empty. `iss_valid` is all zero and `disp_stall` is low until something is dispatched.
- R2: An accepted dispatch group is written in lane order, lane 0 first, behind every entry already held. Lanes whose `disp_valid` bit is low are skipped and take no entry.
- R3: When the number of set `disp_valid` bits exceeds the free entries (DEPTH minus held entries), `disp_stall` is high in that same cycle and no lane of the group is written. A group that exactly fills the free entries is accepted.
- R4: A source is recorded as ready at insertion if its dispatch ready flag is set, or if its tag equals a valid broadcast tag in the insertion cycle. An entry with both sources ready can issue in the cycle after dispatch.
- R5: A waiting source becomes ready when its tag equals any valid `bcast_tag` lane. The entry can issue in the cycle after that broadcast, and never in the broadcast cycle itself.
- R6: Each cycle, up to ISSUE_W of the oldest ready entries issue. Slot 0 holds the oldest of them, and the valid slots are contiguous from slot 0. A ready younger entry issues ahead of an older entry that is still waiting.
- R7: An issued entry leaves the queue at the end of its issue cycle. It is never presented again, and the relative age order of the entries that remain is kept.
- R8: With `flush_valid` high, every entry whose sequence number is younger than `flush_seq` is removed at the end of the cycle. It does not issue in that cycle either. Younger means that (seq - flush_seq) modulo 2^SEQ_W is nonzero and below 2^(SEQ_W-1). Older and equal entries are kept.
- R9: A dispatch group presented in a cycle with `flush_valid` high is discarded.
- R10: Each valid issue slot carries the destination tag, sequence number and payload of the entry it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | DISP_W | Per-lane dispatch valid |
| disp_src0_tag | input | DISP_W x TAG_W | First source physical tag per lane |
| disp_src0_rdy | input | DISP_W | First source already ready |
| disp_src1_tag | input | DISP_W x TAG_W | Second source physical tag per lane |
| disp_src1_rdy | input | DISP_W | Second source already ready |
| disp_dst_tag | input | DISP_W x TAG_W | Destination physical tag per lane |
| disp_seq | input | DISP_W x SEQ_W | Instruction sequence number per lane |
| disp_payload | input | DISP_W x PAY_W | Opaque payload per lane |
| disp_stall | output | 1 | Group does not fit; it is not written |
| bcast_valid | input | BCAST_W | Result broadcast valid per lane |
| bcast_tag | input | BCAST_W x TAG_W | Broadcast destination tags |
| flush_valid | input | 1 | Remove entries younger than flush_seq |
| flush_seq | input | SEQ_W | Flush boundary sequence number |
| iss_valid | output | ISSUE_W | Issue slot valid, slot 0 oldest |
| iss_dst_tag | output | ISSUE_W x TAG_W | Destination tag per issue slot |
| iss_seq | output | ISSUE_W x SEQ_W | Sequence number per issue slot |
| iss_payload | output | ISSUE_W x PAY_W | Payload per issue slot |

## Verification
A corrupted ready bit or a missed wakeup shows up on `iss_valid` in the first cycle after the relevant broadcast. The entry then either issues a cycle early or never issues, and the drain sequence loses a sequence number. A compaction fault breaks age order or duplicates an entry, which the bench sees in the next cycle as an out-of-order or repeated sequence number across the issue slots. A wrong occupancy count shows immediately as a wrong `disp_stall` decision at the full boundary, or a few cycles later as a stalled group appearing on the issue ports.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int TAG_W = 7;
    localparam int SEQ_W = 8;
    localparam int PAY_W = 32;

    typedef struct packed {
        logic             vld;
        logic             rdy0;
        logic             rdy1;
        logic [TAG_W-1:0] src0;
        logic [TAG_W-1:0] src1;
        logic [TAG_W-1:0] dst;
        logic [SEQ_W-1:0] seq;
        logic [PAY_W-1:0] pay;
    } iq_entry_t;

    // true when a is strictly younger than ref_s under modular ordering
    function automatic logic seq_younger(input logic [SEQ_W-1:0] a,
                                         input logic [SEQ_W-1:0] ref_s);
        logic [SEQ_W-1:0] d;
        d = a - ref_s;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup
    import iq_pkg::*;
#(
    parameter int BCAST_W = 4
) (
    input  iq_entry_t                       ent_in,
    input  logic [BCAST_W-1:0]              bc_vld,
    input  logic [BCAST_W-1:0][TAG_W-1:0]   bc_tag,
    output iq_entry_t                       ent_out
);
    logic hit0, hit1;

    always_comb begin
        hit0 = 1'b0;
        hit1 = 1'b0;
        for (int b = 0; b < BCAST_W; b++) begin
            if (bc_vld[b] && bc_tag[b] == ent_in.src0) hit0 = 1'b1;
            if (bc_vld[b] && bc_tag[b] == ent_in.src1) hit1 = 1'b1;
        end
        ent_out      = ent_in;
        ent_out.rdy0 = ent_in.rdy0 | hit0;
        ent_out.rdy1 = ent_in.rdy1 | hit1;
    end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int DEPTH   = 20,
    parameter int ISSUE_W = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int NW     = $clog2(ISSUE_W + 1)
) (
    input  logic [DEPTH-1:0]                 req,
    output logic [DEPTH-1:0]                 gnt,
    output logic [ISSUE_W-1:0]               slot_vld,
    output logic [ISSUE_W-1:0][IDX_W-1:0]    slot_idx
);
    logic [NW-1:0] n;

    // position order is age order: scan from the head
    always_comb begin
        gnt      = '0;
        slot_vld = '0;
        slot_idx = '0;
        n        = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (req[i] && n < NW'(ISSUE_W)) begin
                gnt[i]        = 1'b1;
                slot_vld[n]   = 1'b1;
                slot_idx[n]   = IDX_W'(i);
                n             = n + 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_compact.sv
module iq_compact
    import iq_pkg::*;
#(
    parameter int DEPTH  = 20,
    parameter int DISP_W = 4,
    localparam int PW    = $clog2(DEPTH + DISP_W + 1)
) (
    input  iq_entry_t           upd  [DEPTH],
    input  logic [DEPTH-1:0]    keep,
    input  iq_entry_t           newe [DISP_W],
    input  logic [DISP_W-1:0]   new_vld,
    output iq_entry_t           nxt  [DEPTH]
);
    logic [PW-1:0] pos;

    always_comb begin
        for (int j = 0; j < DEPTH; j++) nxt[j] = '0;
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i] && pos < PW'(DEPTH)) begin
                nxt[pos] = upd[i];
                pos      = pos + 1'b1;
            end
        end
        for (int d = 0; d < DISP_W; d++) begin
            if (new_vld[d] && pos < PW'(DEPTH)) begin
                nxt[pos] = newe[d];
                pos      = pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_top.sv
module iq_top
    import iq_pkg::*;
#(
    parameter int DEPTH   = 20,
    parameter int DISP_W  = 4,
    parameter int ISSUE_W = 4,
    parameter int BCAST_W = 4,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int GW     = $clog2(DISP_W + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [DISP_W-1:0]                 disp_valid,
    input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src0_tag,
    input  logic [DISP_W-1:0]                 disp_src0_rdy,
    input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src1_tag,
    input  logic [DISP_W-1:0]                 disp_src1_rdy,
    input  logic [DISP_W-1:0][TAG_W-1:0]      disp_dst_tag,
    input  logic [DISP_W-1:0][SEQ_W-1:0]      disp_seq,
    input  logic [DISP_W-1:0][PAY_W-1:0]      disp_payload,
    output logic                              disp_stall,
    input  logic [BCAST_W-1:0]                bcast_valid,
    input  logic [BCAST_W-1:0][TAG_W-1:0]     bcast_tag,
    input  logic                              flush_valid,
    input  logic [SEQ_W-1:0]                  flush_seq,
    output logic [ISSUE_W-1:0]                iss_valid,
    output logic [ISSUE_W-1:0][TAG_W-1:0]     iss_dst_tag,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]     iss_seq,
    output logic [ISSUE_W-1:0][PAY_W-1:0]     iss_payload
);
    iq_entry_t q     [DEPTH];
    iq_entry_t q_wk  [DEPTH];
    iq_entry_t q_nxt [DEPTH];
    iq_entry_t raw   [DISP_W];
    iq_entry_t ins   [DISP_W];

    logic [DEPTH-1:0]              ent_vld, req, gnt, kill, keep;
    logic [ISSUE_W-1:0][IDX_W-1:0] slot_idx;
    logic [CNT_W-1:0]              occ;
    logic [GW-1:0]                 grp;
    logic                          accept;
    logic [DISP_W-1:0]             new_vld;

    // per-entry state: wakeup, candidacy, flush kill
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        iq_wakeup #(.BCAST_W(BCAST_W)) u_wk (
            .ent_in (q[i]),
            .bc_vld (bcast_valid),
            .bc_tag (bcast_tag),
            .ent_out(q_wk[i])
        );
        assign ent_vld[i] = q[i].vld;
        assign kill[i]    = flush_valid && q[i].vld && seq_younger(q[i].seq, flush_seq);
        assign req[i]     = q[i].vld && q[i].rdy0 && q[i].rdy1 && !kill[i];
        assign keep[i]    = q[i].vld && !gnt[i] && !kill[i];
    end

    // incoming lanes, woken by same-cycle broadcasts
    for (genvar d = 0; d < DISP_W; d++) begin : g_lane
        always_comb begin
            raw[d].vld  = 1'b1;
            raw[d].rdy0 = disp_src0_rdy[d];
            raw[d].rdy1 = disp_src1_rdy[d];
            raw[d].src0 = disp_src0_tag[d];
            raw[d].src1 = disp_src1_tag[d];
            raw[d].dst  = disp_dst_tag[d];
            raw[d].seq  = disp_seq[d];
            raw[d].pay  = disp_payload[d];
        end
        iq_wakeup #(.BCAST_W(BCAST_W)) u_wk_in (
            .ent_in (raw[d]),
            .bc_vld (bcast_valid),
            .bc_tag (bcast_tag),
            .ent_out(ins[d])
        );
        assign new_vld[d] = disp_valid[d] && accept;
    end

    assign occ        = CNT_W'($countones(ent_vld));
    assign grp        = GW'($countones(disp_valid));
    assign disp_stall = (CNT_W'(grp) > CNT_W'(DEPTH) - occ);
    assign accept     = (|disp_valid) && !disp_stall && !flush_valid;

    iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_sel (
        .req     (req),
        .gnt     (gnt),
        .slot_vld(iss_valid),
        .slot_idx(slot_idx)
    );

    for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
        assign iss_dst_tag[k] = q[slot_idx[k]].dst;
        assign iss_seq[k]     = q[slot_idx[k]].seq;
        assign iss_payload[k] = q[slot_idx[k]].pay;
    end

    iq_compact #(.DEPTH(DEPTH), .DISP_W(DISP_W)) u_cmp (
        .upd    (q_wk),
        .keep   (keep),
        .newe   (ins),
        .new_vld(new_vld),
        .nxt    (q_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) q[i] <= q_nxt[i];
        end
    end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
    parameter int DEPTH   = 20,
    parameter int DISP_W  = 4,
    parameter int ISSUE_W = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [CNT_W-1:0]   occ,
    input logic [DEPTH-1:0]   ent_vld,
    input logic [DISP_W-1:0]  disp_valid,
    input logic               disp_stall,
    input logic               flush_valid,
    input logic [ISSUE_W-1:0] iss_valid
);
    a_r1_empty_after_reset: assert property (@(posedge clk)
        rst |=> (occ == '0));

    a_r3_stall_no_growth: assert property (@(posedge clk) disable iff (rst)
        disp_stall |=> (occ <= $past(occ)));

    a_r9_flush_no_growth: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> (occ <= $past(occ)));

    a_r6_issue_within_held: assert property (@(posedge clk) disable iff (rst)
        $countones(iss_valid) <= int'(occ));

    a_r7_issued_leave: assert property (@(posedge clk) disable iff (rst)
        (disp_valid == '0 && !flush_valid) |=>
            (int'(occ) == int'($past(occ)) - $countones($past(iss_valid))));

    for (genvar k = 0; k + 1 < ISSUE_W; k++) begin : g_slots
        a_r6_slots_packed: assert property (@(posedge clk) disable iff (rst)
            iss_valid[k+1] |-> iss_valid[k]);
    end

    for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_ents
        a_r7_queue_packed: assert property (@(posedge clk) disable iff (rst)
            ent_vld[i+1] |-> ent_vld[i]);
    end
endmodule

bind iq_top iq_checker #(
    .DEPTH  (DEPTH),
    .DISP_W (DISP_W),
    .ISSUE_W(ISSUE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .occ        (occ),
    .ent_vld    (ent_vld),
    .disp_valid (disp_valid),
    .disp_stall (disp_stall),
    .flush_valid(flush_valid),
    .iss_valid  (iss_valid)
);

// File: tb/iq_top_test.sv
`timescale 1ns/1ps
module iq_top_test;
    import iq_pkg::*;

    localparam int DEPTH   = 20;
    localparam int DISP_W  = 4;
    localparam int ISSUE_W = 4;
    localparam int BCAST_W = 4;

    logic                              clk = 1'b0;
    logic                              rst;
    logic [DISP_W-1:0]                 disp_valid;
    logic [DISP_W-1:0][TAG_W-1:0]      disp_src0_tag;
    logic [DISP_W-1:0]                 disp_src0_rdy;
    logic [DISP_W-1:0][TAG_W-1:0]      disp_src1_tag;
    logic [DISP_W-1:0]                 disp_src1_rdy;
    logic [DISP_W-1:0][TAG_W-1:0]      disp_dst_tag;
    logic [DISP_W-1:0][SEQ_W-1:0]      disp_seq;
    logic [DISP_W-1:0][PAY_W-1:0]      disp_payload;
    logic                              disp_stall;
    logic [BCAST_W-1:0]                bcast_valid;
    logic [BCAST_W-1:0][TAG_W-1:0]     bcast_tag;
    logic                              flush_valid;
    logic [SEQ_W-1:0]                  flush_seq;
    logic [ISSUE_W-1:0]                iss_valid;
    logic [ISSUE_W-1:0][TAG_W-1:0]     iss_dst_tag;
    logic [ISSUE_W-1:0][SEQ_W-1:0]     iss_seq;
    logic [ISSUE_W-1:0][PAY_W-1:0]     iss_payload;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    iq_top #(.DEPTH(DEPTH), .DISP_W(DISP_W), .ISSUE_W(ISSUE_W), .BCAST_W(BCAST_W)) uut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy), .disp_dst_tag(disp_dst_tag),
        .disp_seq(disp_seq), .disp_payload(disp_payload), .disp_stall(disp_stall),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .flush_valid(flush_valid), .flush_seq(flush_seq),
        .iss_valid(iss_valid), .iss_dst_tag(iss_dst_tag), .iss_seq(iss_seq), .iss_payload(iss_payload)
    );

    task automatic clear_inputs();
        disp_valid    = '0;
        disp_src0_tag = '0;
        disp_src0_rdy = '0;
        disp_src1_tag = '0;
        disp_src1_rdy = '0;
        disp_dst_tag  = '0;
        disp_seq      = '0;
        disp_payload  = '0;
        bcast_valid   = '0;
        bcast_tag     = '0;
        flush_valid   = 1'b0;
        flush_seq     = '0;
    endtask

    // one edge; inputs cleared just after it, outputs then show new state
    task automatic cycle();
        @(posedge clk);
        #1;
        clear_inputs();
    endtask

    task automatic put(input int lane, input int seq, input int tag0, input bit r0);
        disp_valid[lane]    = 1'b1;
        disp_seq[lane]      = SEQ_W'(seq);
        disp_src0_tag[lane] = TAG_W'(tag0);
        disp_src0_rdy[lane] = r0;
        disp_src1_tag[lane] = TAG_W'(seq + 3);
        disp_src1_rdy[lane] = 1'b1;
        disp_dst_tag[lane]  = TAG_W'(seq + 1);
        disp_payload[lane]  = 32'hA500_0000 + PAY_W'(seq);
    endtask

    task automatic bcast(input int lane, input int tag);
        bcast_valid[lane] = 1'b1;
        bcast_tag[lane]   = TAG_W'(tag);
    endtask

    // expect n slots valid, carrying consecutive seq values from s0
    task automatic check_issue(input int n, input int s0, input string req);
        bit ok = 1'b1;
        logic [ISSUE_W-1:0] ev;
        #1;
        checks++;
        ev = ISSUE_W'((1 << n) - 1);
        if (iss_valid !== ev) ok = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (iss_seq[k] !== SEQ_W'(s0 + k)) ok = 1'b0;
            if (iss_dst_tag[k] !== TAG_W'(s0 + k + 1)) ok = 1'b0;
            if (iss_payload[k] !== 32'hA500_0000 + PAY_W'(s0 + k)) ok = 1'b0;
        end
        if (!ok) begin
            errors++;
            $display("FAIL %s: iss_valid=%b seq0=%0d seq1=%0d seq2=%0d seq3=%0d, expected valid=%b seq from %0d",
                     req, iss_valid, iss_seq[0], iss_seq[1], iss_seq[2], iss_seq[3], ev, s0);
        end
    endtask

    task automatic check_stall(input bit exp, input string req);
        #1;
        checks++;
        if (disp_stall !== exp) begin
            errors++;
            $display("FAIL %s: disp_stall=%b expected %b", req, disp_stall, exp);
        end
    endtask

    task automatic t_reset();
        check_issue(0, 0, "R1 no issue after reset");
        check_stall(1'b0, "R1 no stall after reset");
    endtask

    task automatic t_ready_at_dispatch();
        for (int l = 0; l < 4; l++) put(l, l, 9, 1'b1);
        cycle();
        check_issue(4, 0, "R4 R10 ready group issues next cycle");
        cycle();
        check_issue(0, 0, "R7 issued entries gone");
        put(0, 5, 9, 1'b1);
        put(2, 6, 9, 1'b1);
        cycle();
        check_issue(2, 5, "R2 sparse lanes packed in lane order");
        cycle();
    endtask

    task automatic t_wakeup();
        put(0, 10, 10, 1'b0);
        put(1, 11, 10, 1'b0);
        cycle();
        check_issue(0, 0, "R5 waiting entries hold");
        bcast(2, 10);
        check_issue(0, 0, "R5 no issue in broadcast cycle");
        cycle();
        check_issue(2, 10, "R5 issue after broadcast");
        cycle();
        check_issue(0, 0, "R7 woken entries removed");
    endtask

    task automatic t_same_cycle_wake();
        put(0, 20, 20, 1'b0);
        bcast(0, 20);
        cycle();
        check_issue(1, 20, "R4 same-cycle broadcast at insert");
        cycle();
    endtask

    task automatic t_out_of_order();
        put(0, 30, 33, 1'b0);
        put(1, 31, 9, 1'b1);
        cycle();
        check_issue(1, 31, "R6 younger ready passes older waiting");
        cycle();
        check_issue(0, 0, "R6 older still waiting");
        bcast(3, 33);
        cycle();
        check_issue(1, 30, "R6 older issues after wake");
        cycle();
    endtask

    task automatic t_oldest_first();
        for (int l = 0; l < 4; l++) put(l, 40 + l, 44, 1'b0);
        cycle();
        for (int l = 0; l < 4; l++) put(l, 44 + l, 44, 1'b0);
        cycle();
        bcast(1, 44);
        cycle();
        check_issue(4, 40, "R6 four oldest of eight");
        cycle();
        check_issue(4, 44, "R7 remaining keep age order");
        cycle();
        check_issue(0, 0, "R7 drained");
    endtask

    task automatic t_stall();
        for (int g = 0; g < 4; g++) begin
            for (int l = 0; l < 4; l++) put(l, 50 + 4 * g + l, 55, 1'b0);
            cycle();
        end
        put(0, 66, 55, 1'b0);
        cycle();
        for (int l = 0; l < 4; l++) put(l, 100 + l, 9, 1'b1);
        check_stall(1'b1, "R3 group of four with three free");
        cycle();
        check_issue(0, 0, "R3 stalled group not written");
        for (int l = 0; l < 3; l++) put(l, 67 + l, 9, 1'b1);
        check_stall(1'b0, "R3 exact fit accepted");
        cycle();
        check_issue(3, 67, "R3 exact-fit group issues");
        cycle();
        bcast(0, 55);
        cycle();
        check_issue(4, 50, "R7 drain 1");
        cycle();
        check_issue(4, 54, "R7 drain 2");
        cycle();
        check_issue(4, 58, "R7 drain 3");
        cycle();
        check_issue(4, 62, "R7 drain 4");
        cycle();
        check_issue(1, 66, "R7 drain 5");
        cycle();
        check_issue(0, 0, "R3 no stalled entry left behind");
    endtask

    task automatic t_flush();
        for (int l = 0; l < 4; l++) put(l, 80 + l, 89, 1'b0);
        cycle();
        for (int l = 0; l < 4; l++) put(l, 84 + l, 9, 1'b1);
        cycle();
        flush_valid = 1'b1;
        flush_seq   = SEQ_W'(81);
        put(0, 90, 9, 1'b1);
        check_issue(0, 0, "R8 flushed entries do not issue in flush cycle");
        cycle();
        check_issue(0, 0, "R9 dispatch during flush discarded");
        bcast(0, 89);
        cycle();
        check_issue(2, 80, "R8 older and equal entries kept");
        cycle();
        check_issue(0, 0, "R8 younger entries removed");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_ready_at_dispatch();
        t_wakeup();
        t_same_cycle_wake();
        t_out_of_order();
        t_oldest_first();
        t_stall();
        t_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule